// File: doc/BRIEF.md
# Load Stride Confidence Predictor

This block watches the stream of decoded loads and learns, for each static load, the distance between the addresses of successive executions of that load. Each request carries a load's PC and its effective address. The PC selects one slot of a direct-mapped table, and the full PC is compared against the stored tag. The block answers one cycle later with five values: whether the load was already tracked, the stride it now holds, the last address it saw, its confidence count, and a trigger. The trigger tells the speculative vectorization logic downstream that this load has repeated the same stride often enough to be worth replicating.

A request may also ask for the predicted addresses of the next N executions of the load. These come back in the same response cycle. The address of rank n is the last address plus n times the stride, so replicas can be issued early against the memory system. A PC that misses, or that collides with a different PC in its slot, takes over the slot with a cleared stride and a cleared confidence.

Top module: `ld_stride_tracker`

## Requirements
- R1: After reset no response is valid and every table slot is empty, so the first access to any PC reports a miss.
- R2: On a miss the slot is taken with last address equal to the request address, and the stride and confidence are both zero. The response shows hit=0, stride 0 and confidence 0.
- R3: On a hit the new stride is the request address minus the stored last address, modulo 2^ADDR_W. When it equals the stored stride, the confidence rises by one and saturates at 3.
- R4: On a hit whose new stride differs from the stored one, the confidence returns to 0 and the stored stride becomes the new stride.
- R5: The stored last address is overwritten with the request address on every request, hit or miss, and the response shows it.
- R6: rsp_trigger is 1 exactly when the updated confidence is 2 or more.
- R7: When rep_req accompanies a request, rep_valid is 1 in the response cycle. Slice k of rep_addr, bits [k*ADDR_W +: ADDR_W] with k = 0..REP_N-1, holds the last address plus (k+1) times the stride, modulo 2^ADDR_W.
- R8: A stride of zero is tracked like any other stride. Repeated identical addresses build confidence and fire the trigger.
- R9: The slot is chosen by req_pc[IDX_W-1:0]. A different PC with the same low bits is a miss and replaces the slot, so the earlier PC then misses too.
- R10: The response appears on the cycle after the request. A cycle without req_valid gives rsp_valid=0 and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load lookup/update request |
| req_pc | input | PC_W | PC of the load |
| req_addr | input | ADDR_W | Effective address of the load |
| rep_req | input | 1 | Ask for replica addresses with this request |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | PC was present in the table |
| rsp_stride | output | ADDR_W | Updated stride (two's complement) |
| rsp_last_addr | output | ADDR_W | Updated last address |
| rsp_conf | output | 2 | Updated confidence |
| rsp_trigger | output | 1 | Confidence reached the firing level |
| rep_valid | output | 1 | Replica addresses valid |
| rep_addr | output | REP_N*ADDR_W | Replica addresses, rank 1 in the low slice |

## Verification
The hardest state to reach is a slot that has been evicted by an aliasing PC while the original load still has a stable stride. The original load must miss on its next visit and start again from zero confidence, not resume. The stimulus trains one PC to saturation, then sends a second PC that differs only above the index bits, then returns to the first PC. Idle cycles and a pseudo-random mix of four PCs with changing strides are placed between the directed cases. This shows that only requests change the table, and the behavioural model is compared on every clock.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
    typedef logic [1:0] conf_t;
    localparam conf_t CONF_MAX  = 2'd3;
    localparam conf_t CONF_FIRE = 2'd2;
endpackage

// File: rtl/stride_tbl.sv
module stride_tbl #(
    parameter int ENTRIES = 16,
    parameter int PC_W    = 32,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 rd_vld,
    output logic [PC_W-1:0]      rd_tag,
    output logic [ADDR_W-1:0]    rd_last,
    output logic [ADDR_W-1:0]    rd_stride,
    output lsp_pkg::conf_t       rd_conf,
    input  logic                 wr_en,
    input  logic [PC_W-1:0]      wr_tag,
    input  logic [ADDR_W-1:0]    wr_last,
    input  logic [ADDR_W-1:0]    wr_stride,
    input  lsp_pkg::conf_t       wr_conf
);
    typedef struct packed {
        logic                vld;
        logic [PC_W-1:0]     tag;
        logic [ADDR_W-1:0]   last;
        logic [ADDR_W-1:0]   stride;
        lsp_pkg::conf_t      conf;
    } slot_t;

    slot_t slot_d [ENTRIES];
    slot_t slot_q [ENTRIES];

    // Write goes to the slot being read this cycle.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            slot_d[i] = slot_q[i];
        end
        if (wr_en) begin
            slot_d[rd_idx] = '{vld: 1'b1, tag: wr_tag, last: wr_last,
                               stride: wr_stride, conf: wr_conf};
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) slot_q[i] <= '0;
            else        slot_q[i] <= slot_d[i];
        end
    end

    assign rd_vld    = slot_q[rd_idx].vld;
    assign rd_tag    = slot_q[rd_idx].tag;
    assign rd_last   = slot_q[rd_idx].last;
    assign rd_stride = slot_q[rd_idx].stride;
    assign rd_conf   = slot_q[rd_idx].conf;
endmodule

// File: rtl/stride_upd.sv
module stride_upd #(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 32
) (
    input  logic               ent_vld,
    input  logic [PC_W-1:0]    ent_tag,
    input  logic [ADDR_W-1:0]  ent_last,
    input  logic [ADDR_W-1:0]  ent_stride,
    input  lsp_pkg::conf_t     ent_conf,
    input  logic [PC_W-1:0]    cur_pc,
    input  logic [ADDR_W-1:0]  cur_addr,
    output logic               hit,
    output logic [ADDR_W-1:0]  nxt_stride,
    output lsp_pkg::conf_t     nxt_conf
);
    logic [ADDR_W-1:0] delta;

    always_comb begin
        hit        = ent_vld && (ent_tag == cur_pc);
        delta      = cur_addr - ent_last;
        nxt_stride = '0;
        nxt_conf   = '0;
        if (hit) begin
            if (delta == ent_stride) begin
                nxt_stride = ent_stride;
                nxt_conf   = (ent_conf == lsp_pkg::CONF_MAX) ? ent_conf
                                                             : ent_conf + 2'd1;
            end else begin
                nxt_stride = delta;
                nxt_conf   = '0;
            end
        end
    end
endmodule

// File: rtl/replica_gen.sv
module replica_gen #(
    parameter int ADDR_W = 32,
    parameter int REP_N  = 4
) (
    input  logic [ADDR_W-1:0]        base,
    input  logic [ADDR_W-1:0]        stride,
    output logic [REP_N*ADDR_W-1:0]  addrs
);
    for (genvar k = 0; k < REP_N; k++) begin : g_rank
        assign addrs[k*ADDR_W +: ADDR_W] = base + stride * ADDR_W'(k + 1);
    end
endmodule

// File: rtl/ld_stride_tracker.sv
module ld_stride_tracker #(
    parameter int ENTRIES = 16,
    parameter int PC_W    = 32,
    parameter int ADDR_W  = 32,
    parameter int REP_N   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [PC_W-1:0]          req_pc,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     rep_req,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [ADDR_W-1:0]        rsp_stride,
    output logic [ADDR_W-1:0]        rsp_last_addr,
    output logic [1:0]               rsp_conf,
    output logic                     rsp_trigger,
    output logic                     rep_valid,
    output logic [REP_N*ADDR_W-1:0]  rep_addr
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic                     valid;
        logic                     hit;
        logic [ADDR_W-1:0]        stride;
        logic [ADDR_W-1:0]        last;
        lsp_pkg::conf_t           conf;
        logic                     trig;
        logic                     rvalid;
        logic [REP_N*ADDR_W-1:0]  raddr;
    } out_t;

    out_t out_d, out_q;

    logic               e_vld;
    logic [PC_W-1:0]    e_tag;
    logic [ADDR_W-1:0]  e_last;
    logic [ADDR_W-1:0]  e_stride;
    lsp_pkg::conf_t     e_conf;
    logic               u_hit;
    logic [ADDR_W-1:0]  u_stride;
    lsp_pkg::conf_t     u_conf;
    logic [REP_N*ADDR_W-1:0] u_rep;

    stride_tbl #(.ENTRIES(ENTRIES), .PC_W(PC_W), .ADDR_W(ADDR_W)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (req_pc[IDX_W-1:0]),
        .rd_vld    (e_vld),
        .rd_tag    (e_tag),
        .rd_last   (e_last),
        .rd_stride (e_stride),
        .rd_conf   (e_conf),
        .wr_en     (req_valid),
        .wr_tag    (req_pc),
        .wr_last   (req_addr),
        .wr_stride (u_stride),
        .wr_conf   (u_conf)
    );

    stride_upd #(.PC_W(PC_W), .ADDR_W(ADDR_W)) u_upd (
        .ent_vld    (e_vld),
        .ent_tag    (e_tag),
        .ent_last   (e_last),
        .ent_stride (e_stride),
        .ent_conf   (e_conf),
        .cur_pc     (req_pc),
        .cur_addr   (req_addr),
        .hit        (u_hit),
        .nxt_stride (u_stride),
        .nxt_conf   (u_conf)
    );

    // Replicas project forward from the address just seen.
    replica_gen #(.ADDR_W(ADDR_W), .REP_N(REP_N)) u_rep_gen (
        .base   (req_addr),
        .stride (u_stride),
        .addrs  (u_rep)
    );

    always_comb begin
        out_d        = out_q;
        out_d.valid  = req_valid;
        out_d.rvalid = req_valid && rep_req;
        if (req_valid) begin
            out_d.hit    = u_hit;
            out_d.stride = u_stride;
            out_d.last   = req_addr;
            out_d.conf   = u_conf;
            out_d.trig   = (u_conf >= lsp_pkg::CONF_FIRE);
            if (rep_req) out_d.raddr = u_rep;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rsp_valid     = out_q.valid;
    assign rsp_hit       = out_q.hit;
    assign rsp_stride    = out_q.stride;
    assign rsp_last_addr = out_q.last;
    assign rsp_conf      = out_q.conf;
    assign rsp_trigger   = out_q.trig;
    assign rep_valid     = out_q.rvalid;
    assign rep_addr      = out_q.raddr;
endmodule

// File: rtl/lsp_chk.sv
module lsp_chk #(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 32,
    parameter int REP_N  = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic [PC_W-1:0]          req_pc,
    input logic [ADDR_W-1:0]        req_addr,
    input logic                     rsp_valid,
    input logic                     rsp_hit,
    input logic [ADDR_W-1:0]        rsp_stride,
    input logic [ADDR_W-1:0]        rsp_last_addr,
    input logic [1:0]               rsp_conf,
    input logic                     rsp_trigger,
    input logic                     rep_valid,
    input logic [REP_N*ADDR_W-1:0]  rep_addr
);
    p_resp_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_alloc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_stride == '0 && rsp_conf == 2'd0));
    p_last_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_last_addr == $past(req_addr)));
    p_fire_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_trigger == (rsp_conf >= 2'd2)));
    p_fire_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_trigger) |-> rsp_hit);
    p_rank_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |-> (rep_addr[ADDR_W-1:0] == rsp_last_addr + rsp_stride));
    p_rep_with_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |-> rsp_valid);
endmodule

bind ld_stride_tracker lsp_chk #(.PC_W(PC_W), .ADDR_W(ADDR_W), .REP_N(REP_N)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_pc        (req_pc),
    .req_addr      (req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_stride    (rsp_stride),
    .rsp_last_addr (rsp_last_addr),
    .rsp_conf      (rsp_conf),
    .rsp_trigger   (rsp_trigger),
    .rep_valid     (rep_valid),
    .rep_addr      (rep_addr)
);

// File: tb/sim_ld_stride_tracker.sv
`timescale 1ns/1ps
module sim_ld_stride_tracker;
    localparam int NENT = 16;
    localparam int NREP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [31:0] req_pc = '0;
    logic [31:0] req_addr = '0;
    logic rep_req = 1'b0;
    logic rsp_valid, rsp_hit, rsp_trigger, rep_valid;
    logic [31:0] rsp_stride, rsp_last_addr;
    logic [1:0] rsp_conf;
    logic [NREP*32-1:0] rep_addr;

    always #4 clk = ~clk;

    ld_stride_tracker #(.ENTRIES(NENT), .PC_W(32), .ADDR_W(32), .REP_N(NREP)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
        .req_addr(req_addr), .rep_req(rep_req), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_stride(rsp_stride), .rsp_last_addr(rsp_last_addr),
        .rsp_conf(rsp_conf), .rsp_trigger(rsp_trigger), .rep_valid(rep_valid),
        .rep_addr(rep_addr));

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Behavioural reference: what each direct-mapped slot should remember.
    bit          m_vld  [NENT];
    logic [31:0] m_pc   [NENT];
    logic [31:0] m_last [NENT];
    logic [31:0] m_str  [NENT];
    int          m_conf [NENT];

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: drive after a falling edge, compare at the next falling edge.
    task automatic step(input bit v, input logic [31:0] pc, input logic [31:0] addr,
                        input bit rep, input string tag);
        int idx;
        bit e_hit;
        logic [31:0] e_str;
        logic [31:0] ns;
        int e_conf;
        req_valid = v; req_pc = pc; req_addr = addr; rep_req = rep;
        idx = int'(pc[3:0]);
        e_hit = 1'b0; e_str = '0; e_conf = 0;
        if (v) begin
            e_hit = m_vld[idx] && (m_pc[idx] == pc);
            if (e_hit) begin
                ns = addr - m_last[idx];
                if (ns == m_str[idx]) begin
                    e_str = m_str[idx];
                    e_conf = (m_conf[idx] < 3) ? m_conf[idx] + 1 : 3;
                end else begin
                    e_str = ns;
                    e_conf = 0;
                end
            end
            m_vld[idx] = 1'b1; m_pc[idx] = pc; m_last[idx] = addr;
            m_str[idx] = e_str; m_conf[idx] = e_conf;
        end
        @(negedge clk);
        chk(rsp_valid == v, "R10", 128'(rsp_valid), 128'(v));
        if (v) begin
            chk(rsp_hit == e_hit, tag, 128'(rsp_hit), 128'(e_hit));
            chk(rsp_stride == e_str, tag, 128'(rsp_stride), 128'(e_str));
            chk(rsp_last_addr == addr, "R5", 128'(rsp_last_addr), 128'(addr));
            chk(int'(rsp_conf) == e_conf, tag, 128'(rsp_conf), 128'(e_conf));
            chk(rsp_trigger == (e_conf >= 2), "R6", 128'(rsp_trigger), 128'(e_conf >= 2));
            chk(rep_valid == rep, "R7", 128'(rep_valid), 128'(rep));
            if (rep) begin
                for (int k = 1; k <= NREP; k++) begin
                    logic [31:0] ea;
                    ea = addr + e_str * 32'(k);
                    chk(rep_addr[(k-1)*32 +: 32] == ea, "R7",
                        128'(rep_addr[(k-1)*32 +: 32]), 128'(ea));
                end
            end
        end
    endtask

    initial begin
        for (int i = 0; i < NENT; i++) begin
            m_vld[i] = 1'b0; m_pc[i] = '0; m_last[i] = '0; m_str[i] = '0; m_conf[i] = 0;
        end
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R1", 128'(rsp_valid), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1", 128'(rsp_valid), 128'(0));

        // R2/R3: stride 8 training to saturation, replicas on the last ones
        for (int n = 0; n < 7; n++)
            step(1'b1, 32'h0000_1003, 32'h8000 + 32'(n) * 8, n > 3, (n == 0) ? "R2" : "R3");
        // R10: idle cycles leave the slot alone; training resumes at conf 3
        step(1'b0, 32'h0000_1003, 32'hdead, 1'b1, "R10");
        step(1'b0, 32'h0000_1003, 32'hbeef, 1'b0, "R10");
        step(1'b1, 32'h0000_1003, 32'h8000 + 7 * 8, 1'b1, "R10");
        // R4: break the pattern, then lock onto a negative stride
        step(1'b1, 32'h0000_1003, 32'h9000, 1'b1, "R4");
        for (int n = 1; n < 5; n++)
            step(1'b1, 32'h0000_1003, 32'h9000 - 32'(n) * 4, 1'b1, "R4");
        // R8: zero stride builds confidence and fires
        for (int n = 0; n < 5; n++)
            step(1'b1, 32'h0000_2005, 32'h4444, 1'b1, "R8");
        // R9: alias in same slot evicts, original misses afterwards
        step(1'b1, 32'h0000_3003, 32'h100, 1'b0, "R9");
        step(1'b1, 32'h0000_3003, 32'h110, 1'b0, "R9");
        step(1'b1, 32'h0000_1003, 32'h9000 - 5 * 4, 1'b1, "R9");
        step(1'b1, 32'h0000_2005, 32'h4444, 1'b0, "R8");
        // R3: wrap-around stride across the address space
        step(1'b1, 32'h0000_400a, 32'hffff_fff0, 1'b1, "R2");
        step(1'b1, 32'h0000_400a, 32'h0000_0010, 1'b1, "R3");
        step(1'b1, 32'h0000_400a, 32'h0000_0030, 1'b1, "R3");
        // Mixed traffic with changing strides
        begin
            logic [31:0] lcg;
            logic [31:0] cur [4];
            logic [31:0] strd [4];
            lcg = 32'h1234_5678;
            for (int p = 0; p < 4; p++) begin
                cur[p] = 32'h1_0000 * 32'(p + 1); strd[p] = 32'(4 * (p + 1));
            end
            for (int n = 0; n < 400; n++) begin
                int p;
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                p = int'(lcg[17:16]);
                if (lcg[27:24] == 4'h0) strd[p] = {24'h0, lcg[7:0]};
                cur[p] = cur[p] + strd[p];
                step(lcg[30:28] != 3'd0, 32'h0000_5000 + 32'(p) * 32'h13, cur[p],
                     lcg[20], "R3");
            end
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule